// File: doc/BRIEF.md
# Serial Command Word Validator

This block sits behind a three-wire serial port (transfer enable, serial clock, data) and checks the 24-bit command word that opens every transfer. The serial clock is assumed to be synchronised already. It reaches the block as a one-cycle strobe for each rising edge, together with the data bit sampled at that edge and the level of the transfer enable. The block collects the word one bit per strobe. Each field is checked as soon as its last bit arrives: the operation byte, the mode pair, the 13-bit device-select code and the closing bit. The block then either accepts the command or rejects the whole transfer.

On acceptance it pulses a valid strobe for one cycle and holds the decoded operation (read or write) and mode (normal or program) for the rest of the transfer. On rejection it raises a sticky abort flag and ignores the link until the enable drops. The device-select code is fixed per instance by a parameter. The data phases that follow the command word are handled elsewhere. This block only stops listening once it has decided.

Top module: `serial_cmd_validator`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output is 0 after that edge.
- R2: While a transfer is open, the word is taken one bit per `sclk_rise` strobe, first bit = word bit 0, up to bit 23. `cmd_valid` is high for exactly the one cycle after the edge that takes bit 23, and only if every field matched.
- R3: Bits 7..0 are the operation byte: 8'h62 means read and 8'h9D means write. Any other value rejects the transfer, and `cmd_abort` is high from the cycle after bit 7 is taken.
- R4: Bits 9..8 select the mode: {bit9,bit8}=01 is normal and 10 is program. 00 and 11 reject the transfer at bit 9.
- R5: Program mode with the read operation byte rejects the transfer at bit 9.
- R6: Bits 22..10 must equal the `DEV_CODE` parameter, with bit 10 matched against code bit 0. Any mismatch rejects the transfer at bit 22.
- R7: Bit 23 must be 1; a 0 rejects the transfer.
- R8: After a rejection, `cmd_abort` stays high and no `cmd_valid`, operation or mode output is raised until `xfer_active` goes low.
- R9: A low `xfer_active` at any clock edge discards any partial word and clears all outputs after that edge. The next transfer starts again from bit 0.
- R10: After acceptance, the operation and mode outputs hold their values while `xfer_active` stays high, and further strobes change nothing.
- R11: `sclk_rise` strobes while `xfer_active` is low are ignored. A transfer opens one clock after `xfer_active` is first seen high, and strobes are counted from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xfer_active | input | 1 | Transfer enable level of the serial link |
| sclk_rise | input | 1 | One-cycle strobe per synchronised serial clock rising edge |
| sdata | input | 1 | Serial data bit sampled at the strobe |
| cmd_valid | output | 1 | One-cycle pulse when a command word is accepted |
| op_read | output | 1 | Accepted command is a read |
| op_write | output | 1 | Accepted command is a write |
| mode_program | output | 1 | Accepted command selects program mode |
| mode_normal | output | 1 | Accepted command selects normal mode |
| cmd_abort | output | 1 | Transfer rejected; link ignored until enable drops |

## Verification
A wrong bit position or an off-by-one in the bit count shows up at the ports within one strobe of the affected field. An abort then appears one bit too early or too late, or a valid pulse lands in the wrong cycle. A bad state transition shows as a missing clear one cycle after the enable drops, or as a flag that changes under later strobes. The bench compares every output to a queue-based model on every clock, so any of these errors is caught in the cycle in which it first appears.

// File: rtl/svc_pkg.sv
// Shared constants and types for the serial command word validator.
// Field positions follow the bit order on the wire: word bit 0 is received first.
package svc_pkg;
    localparam int CMD_BITS = 24;
    localparam int BYTE_W   = 8;
    localparam int CODE_W   = 13;
    localparam int CNT_W    = $clog2(CMD_BITS);
    localparam int MODE_LO  = BYTE_W;
    localparam int MODE_HI  = MODE_LO + 1;
    localparam int CODE_LO  = MODE_HI + 1;
    localparam int CODE_HI  = CODE_LO + CODE_W - 1;
    localparam int TAIL_BIT = CMD_BITS - 1;

    localparam logic [BYTE_W-1:0] OP_READ_PAT  = 8'h62;
    localparam logic [BYTE_W-1:0] OP_WRITE_PAT = 8'h9D;
    // mode pair written as {bit9, bit8}
    localparam logic [1:0] MODE_NORMAL_PAT  = 2'b01;
    localparam logic [1:0] MODE_PROGRAM_PAT = 2'b10;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RECV,
        ST_DONE,
        ST_IGNORE
    } seq_state_t;

    typedef struct packed {
        logic is_write;
        logic is_read;
        logic prog;
        logic norm;
    } cmd_decode_t;
endpackage

// File: rtl/cmd_bit_shifter.sv
// Collects serial bits into a word, placing each bit at the position given by
// the running bit index. Assumes shift_en is only asserted while a transfer is open.
// Exposes the word as it will look after the current bit (word_next) so that
// field checks can run in the same cycle the bit arrives.
module cmd_bit_shifter #(
    parameter int BITS  = 24,
    parameter int CNT_W = $clog2(BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             shift_en,
    input  logic             sdata,
    output logic [CNT_W-1:0] bit_idx,
    output logic [BITS-1:0]  word_next
);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BITS - 1);

    logic [BITS-1:0] word_q;

    // Merge the incoming bit into its slot of the stored word.
    genvar gi;
    generate
        for (gi = 0; gi < BITS; gi++) begin : g_slot
            assign word_next[gi] = (bit_idx == CNT_W'(gi)) ? sdata : word_q[gi];
        end
    endgenerate

    // Store the word and advance the index on each accepted bit.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            word_q  <= '0;
            bit_idx <= '0;
        end else if (shift_en) begin
            word_q <= word_next;
            if (bit_idx != LAST_IDX) begin
                bit_idx <= bit_idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/cmd_field_check.sv
// Combinational field checker. For the bit now arriving, says whether the field
// that this bit completes is illegal, and decodes operation and mode.
// Assumes word_next holds all bits up to and including bit_idx.
module cmd_field_check
    import svc_pkg::*;
#(
    parameter logic [CODE_W-1:0] DEV_CODE = '0
) (
    input  logic [CMD_BITS-1:0] word_next,
    input  logic [CNT_W-1:0]    bit_idx,
    output logic                stage_fail,
    output logic                last_bit,
    output cmd_decode_t         decode
);
    logic [BYTE_W-1:0] op_byte;
    logic [1:0]        mode_pair;
    logic              op_rd, op_wr, md_norm, md_prog;
    logic [CODE_W-1:0] code_diff;
    logic              code_ok;

    assign op_byte   = word_next[BYTE_W-1:0];
    assign mode_pair = word_next[MODE_HI:MODE_LO];
    assign op_rd     = (op_byte == OP_READ_PAT);
    assign op_wr     = (op_byte == OP_WRITE_PAT);
    assign md_norm   = (mode_pair == MODE_NORMAL_PAT);
    assign md_prog   = (mode_pair == MODE_PROGRAM_PAT);

    // Per-bit comparison of the device-select field against the fixed code.
    genvar gj;
    generate
        for (gj = 0; gj < CODE_W; gj++) begin : g_code
            assign code_diff[gj] = word_next[CODE_LO + gj] ^ DEV_CODE[gj];
        end
    endgenerate
    assign code_ok = ~|code_diff;

    // Pick the check belonging to the field that closes at this bit.
    always_comb begin
        stage_fail = 1'b0;
        if (bit_idx == CNT_W'(BYTE_W - 1)) begin
            stage_fail = !(op_rd || op_wr);
        end else if (bit_idx == CNT_W'(MODE_HI)) begin
            stage_fail = !(md_norm || (md_prog && op_wr));
        end else if (bit_idx == CNT_W'(CODE_HI)) begin
            stage_fail = !code_ok;
        end else if (bit_idx == CNT_W'(TAIL_BIT)) begin
            stage_fail = !word_next[TAIL_BIT];
        end
    end

    assign last_bit        = (bit_idx == CNT_W'(TAIL_BIT));
    assign decode.is_write = op_wr;
    assign decode.is_read  = op_rd;
    assign decode.prog     = md_prog;
    assign decode.norm     = md_norm;
endmodule

// File: rtl/cmd_seq_ctrl.sv
// Transfer sequencer: opens a transfer when the enable is seen high, gates bit
// collection, and registers the accept/reject outcome.
// Assumes stage_fail, last_bit and decode refer to the bit offered this cycle.
module cmd_seq_ctrl
    import svc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        xfer_active,
    input  logic        sclk_rise,
    input  logic        stage_fail,
    input  logic        last_bit,
    input  cmd_decode_t decode,
    output logic        shift_en,
    output logic        clear,
    output logic        cmd_valid,
    output logic        op_read,
    output logic        op_write,
    output logic        mode_program,
    output logic        mode_normal,
    output logic        cmd_abort
);
    seq_state_t state_q, state_d;
    logic       accept, reject;

    assign shift_en = (state_q == ST_RECV) && xfer_active && sclk_rise;
    assign clear    = !xfer_active;
    assign accept   = shift_en && !stage_fail && last_bit;
    assign reject   = shift_en && stage_fail;

    // Next-state selection for the transfer sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (xfer_active) state_d = ST_RECV;
            ST_RECV: begin
                if (!xfer_active)  state_d = ST_IDLE;
                else if (reject)   state_d = ST_IGNORE;
                else if (accept)   state_d = ST_DONE;
            end
            ST_DONE,
            ST_IGNORE: if (!xfer_active) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outcome registers: valid pulse, held decode, sticky abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_valid    <= 1'b0;
            op_read      <= 1'b0;
            op_write     <= 1'b0;
            mode_program <= 1'b0;
            mode_normal  <= 1'b0;
            cmd_abort    <= 1'b0;
        end else begin
            cmd_valid <= accept;
            if (!xfer_active) begin
                op_read      <= 1'b0;
                op_write     <= 1'b0;
                mode_program <= 1'b0;
                mode_normal  <= 1'b0;
                cmd_abort    <= 1'b0;
            end else if (accept) begin
                op_read      <= decode.is_read;
                op_write     <= decode.is_write;
                mode_program <= decode.prog;
                mode_normal  <= decode.norm;
            end else if (reject) begin
                cmd_abort <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/serial_cmd_validator.sv
// Top of the serial command word validator. Assumes sclk_rise is already
// synchronised to clk and lasts one cycle per serial clock rising edge, and that
// the first strobe comes at least one clock after xfer_active goes high.
module serial_cmd_validator
    import svc_pkg::*;
#(
    parameter logic [CODE_W-1:0] DEV_CODE = 13'h0B5A
) (
    input  logic clk,
    input  logic rst_n,
    input  logic xfer_active,
    input  logic sclk_rise,
    input  logic sdata,
    output logic cmd_valid,
    output logic op_read,
    output logic op_write,
    output logic mode_program,
    output logic mode_normal,
    output logic cmd_abort
);
    logic                shift_en, clear, stage_fail, last_bit;
    logic [CNT_W-1:0]    bit_idx;
    logic [CMD_BITS-1:0] word_next;
    cmd_decode_t         decode;

    cmd_bit_shifter #(.BITS(CMD_BITS), .CNT_W(CNT_W)) shifter_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .shift_en  (shift_en),
        .sdata     (sdata),
        .bit_idx   (bit_idx),
        .word_next (word_next)
    );

    cmd_field_check #(.DEV_CODE(DEV_CODE)) check_i (
        .word_next  (word_next),
        .bit_idx    (bit_idx),
        .stage_fail (stage_fail),
        .last_bit   (last_bit),
        .decode     (decode)
    );

    cmd_seq_ctrl seq_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .xfer_active  (xfer_active),
        .sclk_rise    (sclk_rise),
        .stage_fail   (stage_fail),
        .last_bit     (last_bit),
        .decode       (decode),
        .shift_en     (shift_en),
        .clear        (clear),
        .cmd_valid    (cmd_valid),
        .op_read      (op_read),
        .op_write     (op_write),
        .mode_program (mode_program),
        .mode_normal  (mode_normal),
        .cmd_abort    (cmd_abort)
    );
endmodule

// File: rtl/serial_cmd_validator_chk.sv
// Port-level property checker for the serial command word validator.
module serial_cmd_validator_chk (
    input logic clk,
    input logic rst_n,
    input logic xfer_active,
    input logic cmd_valid,
    input logic op_read,
    input logic op_write,
    input logic mode_program,
    input logic mode_normal,
    input logic cmd_abort
);
    // R2
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    // R2
    valid_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> ($onehot({op_read, op_write}) && $onehot({mode_program, mode_normal})));

    // R5
    prog_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_program |-> op_write);

    // R8
    abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_abort |-> (!cmd_valid && !op_read && !op_write));

    // R8
    abort_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_abort && xfer_active) |=> cmd_abort);

    // R9
    idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_active |=> (!cmd_abort && !op_read && !op_write
                          && !mode_program && !mode_normal && !cmd_valid));

    // R10
    hold_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_read || op_write) && xfer_active)
        |=> $stable({op_read, op_write, mode_program, mode_normal}));
endmodule

bind serial_cmd_validator serial_cmd_validator_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .xfer_active  (xfer_active),
    .cmd_valid    (cmd_valid),
    .op_read      (op_read),
    .op_write     (op_write),
    .mode_program (mode_program),
    .mode_normal  (mode_normal),
    .cmd_abort    (cmd_abort)
);

// File: tb/serial_cmd_validator_tb_top.sv
module serial_cmd_validator_tb_top;
    localparam logic [12:0] TB_CODE = 13'h1A5C;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n = 1'b0, xfer_active = 1'b0, sclk_rise = 1'b0, sdata = 1'b0;
    logic cmd_valid, op_read, op_write, mode_program, mode_normal, cmd_abort;

    serial_cmd_validator #(.DEV_CODE(TB_CODE)) dut_i (
        .clk(clk), .rst_n(rst_n), .xfer_active(xfer_active),
        .sclk_rise(sclk_rise), .sdata(sdata),
        .cmd_valid(cmd_valid), .op_read(op_read), .op_write(op_write),
        .mode_program(mode_program), .mode_normal(mode_normal),
        .cmd_abort(cmd_abort)
    );

    int vectors = 0;
    int miscompares = 0;
    bit started = 0;

    // behavioural reference model: 0 idle, 1 receiving, 2 accepted, 3 ignoring
    int   m_state = 0;
    logic q[$];
    logic e_valid = 0, e_rd = 0, e_wr = 0, e_prog = 0, e_norm = 0, e_abort = 0;
    int   n_seen;
    bit   bad;

    function automatic int qval(int lo, int len);
        int v = 0;
        for (int i = 0; i < len; i++) v += int'(q[lo + i]) << i;
        return v;
    endfunction

    task automatic clear_model();
        m_state = 0;
        q.delete();
        e_rd = 0; e_wr = 0; e_prog = 0; e_norm = 0; e_abort = 0;
    endtask

    always @(posedge clk) begin
        e_valid = 0;
        if (!rst_n || !xfer_active) begin
            clear_model();
        end else if (m_state == 0) begin
            m_state = 1;
        end else if (m_state == 1 && sclk_rise) begin
            q.push_back(sdata);
            n_seen = q.size();
            bad = 0;
            if (n_seen == 8)  bad = !(qval(0, 8) == 98 || qval(0, 8) == 157);
            if (n_seen == 10) bad = !((q[8] == 1 && q[9] == 0) ||
                                      (q[8] == 0 && q[9] == 1 && qval(0, 8) == 157));
            if (n_seen == 23) bad = (qval(10, 13) != int'(TB_CODE));
            if (n_seen == 24) bad = (q[23] != 1'b1);
            if (bad) begin
                m_state = 3;
                e_abort = 1;
            end else if (n_seen == 24) begin
                m_state = 2;
                e_valid = 1;
                e_rd = (qval(0, 8) == 98);
                e_wr = (qval(0, 8) == 157);
                e_norm = q[8];
                e_prog = q[9];
            end
        end
        started = 1;
    end

    task automatic cmp(input logic act, input logic exp, input string tag);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // compare every output with the model once per clock
    always @(negedge clk) begin
        if (started) begin
            cmp(cmd_valid,    e_valid, "R2 cmd_valid");
            cmp(cmd_abort,    e_abort, "R8 cmd_abort");
            cmp(op_read,      e_rd,    "R3 op_read");
            cmp(op_write,     e_wr,    "R3 op_write");
            cmp(mode_program, e_prog,  "R4 mode_program");
            cmp(mode_normal,  e_norm,  "R4 mode_normal");
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_bit(logic b);
        @(negedge clk);
        sdata = b; sclk_rise = 1'b1;
        @(negedge clk);
        sclk_rise = 1'b0;
        @(negedge clk);
    endtask

    task automatic send(logic [23:0] w, int nb);
        for (int i = 0; i < nb; i++) pulse_bit(w[i]);
    endtask

    task automatic start_x();
        @(negedge clk); xfer_active = 1'b1; idle(2);
    endtask

    task automatic stop_x();
        @(negedge clk); xfer_active = 1'b0; idle(2);
    endtask

    function automatic logic [23:0] mk(logic [7:0] op, logic [1:0] md, logic [12:0] code, logic tail);
        return {tail, code, md, op};
    endfunction

    task automatic report();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        #(200000 * 8);
        miscompares++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        report();
        $finish;
    end

    initial begin
        idle(3);
        // R1: outputs low while in reset
        cmp(cmd_valid, 0, "R1 valid"); cmp(cmd_abort, 0, "R1 abort");
        cmp(op_read, 0, "R1 read");    cmp(op_write, 0, "R1 write");
        @(negedge clk) rst_n = 1'b1;
        idle(2);

        // R2/R10: read, normal, accepted; extra strobes change nothing
        start_x(); send(mk(8'h62, 2'b01, TB_CODE, 1'b1), 24);
        cmp(op_read, 1, "R2 read accepted"); cmp(mode_normal, 1, "R2 normal");
        send(24'h00F0F, 4);
        cmp(op_read, 1, "R10 read held"); cmp(cmd_abort, 0, "R10 no abort");
        stop_x();
        cmp(op_read, 0, "R9 cleared on close");

        // R4: write, program, accepted
        start_x(); send(mk(8'h9D, 2'b10, TB_CODE, 1'b1), 24);
        cmp(op_write, 1, "R4 write"); cmp(mode_program, 1, "R4 program");
        stop_x();

        // write, normal
        start_x(); send(mk(8'h9D, 2'b01, TB_CODE, 1'b1), 24);
        cmp(mode_normal, 1, "R4 write normal");
        stop_x();

        // R3: bad operation byte aborts right after bit 7
        start_x(); send(mk(8'h63, 2'b01, TB_CODE, 1'b1), 8);
        cmp(cmd_abort, 1, "R3 abort at byte end");
        send(mk(8'h63, 2'b01, TB_CODE, 1'b1) >> 8, 16);
        cmp(cmd_abort, 1, "R8 abort held"); cmp(op_read, 0, "R8 no read");
        stop_x();

        // R4: illegal mode pairs
        start_x(); send(mk(8'h62, 2'b00, TB_CODE, 1'b1), 10);
        cmp(cmd_abort, 1, "R4 mode 00"); stop_x();
        start_x(); send(mk(8'h9D, 2'b11, TB_CODE, 1'b1), 10);
        cmp(cmd_abort, 1, "R4 mode 11"); stop_x();

        // R5: program with read
        start_x(); send(mk(8'h62, 2'b10, TB_CODE, 1'b1), 24);
        cmp(cmd_abort, 1, "R5 program+read"); cmp(mode_program, 0, "R5 no program");
        stop_x();

        // R6: device code mismatch at lowest and highest code bit
        start_x(); send(mk(8'h9D, 2'b01, TB_CODE ^ 13'h0001, 1'b1), 24);
        cmp(cmd_abort, 1, "R6 code bit0"); stop_x();
        start_x(); send(mk(8'h62, 2'b01, TB_CODE ^ 13'h1000, 1'b1), 23);
        cmp(cmd_abort, 1, "R6 code bit12"); stop_x();

        // R7: closing bit zero
        start_x(); send(mk(8'h9D, 2'b01, TB_CODE, 1'b0), 23);
        cmp(cmd_abort, 0, "R7 no abort before tail");
        send(24'h0, 1);
        cmp(cmd_abort, 1, "R7 tail zero"); cmp(op_write, 0, "R7 no write");
        stop_x();

        // R9: drop mid-word then full transfer from scratch
        start_x(); send(mk(8'h9D, 2'b10, TB_CODE, 1'b1), 12);
        stop_x();
        cmp(cmd_abort, 0, "R9 clean after drop");
        start_x(); send(mk(8'h62, 2'b01, TB_CODE, 1'b1), 24);
        cmp(op_read, 1, "R9 restart accepted"); stop_x();

        // R11: strobes while closed are ignored
        send(24'hFFFFFF, 5);
        start_x(); send(mk(8'h9D, 2'b10, TB_CODE, 1'b1), 24);
        cmp(op_write, 1, "R11 write after idle strobes");
        cmp(mode_program, 1, "R11 program");
        stop_x();

        idle(3);
        report();
        $finish;
    end
endmodule